// File: doc/BRIEF.md
# Processor power-mode sequencer

This block moves a processor core from Fullspeed into one of three low-power modes and back again. Standby, Suspend and Hibernate differ in how many clock domains they stop and in which events wake them. A mode request does not act at once. The sequencer first holds it as pending, with every clock still running. It enters the mode only on a clock edge where the requesting instruction has reached writeback and the internal system bus is idle.

There are four clock-enable outputs: core pipeline, peripheral interface, master output, and timer/interrupt. An enable of 1 means the domain runs. An enable of 0 tells the downstream clock gater to hold that clock at logic high, never low. The current mode is reported on a 2-bit output. On a permitted wake event, every enable returns to 1 on the same edge, and the mode output returns to Fullspeed.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode output is 2'b00, all four clock enables are 1, and no entry is pending.
- R2: In Fullspeed with nothing pending, an edge with `req_valid` high and a code of 2'b01, 2'b10 or 2'b11 arms a pending entry into that mode. An edge with code 2'b00 has no effect.
- R3: While an entry is pending, the mode stays 2'b00 and all enables stay 1. On the first edge where `wb_reached` and `bus_idle` are both high, the target mode takes effect on the outputs.
- R4: A request made while an entry is pending, or while in any low-power mode, is ignored. It changes neither the pending target nor the mode.
- R5: In Standby only the core enable is 0. The peripheral, master and timer enables are 1.
- R6: In Suspend the core and peripheral enables are 0. The master and timer enables are 1.
- R7: In Hibernate all four enables are 0.
- R8: Standby and Suspend return to Fullspeed on the edge after `irq` or `wake_tmr` is seen high. All enables become 1 together.
- R9: Hibernate returns to Fullspeed only when `pwr_pin` is high, `wake_tmr` is high, or `cd_n` is low. `irq` alone does not wake it.
- R10: Mode encoding on `mode`: 2'b00 Fullspeed, 2'b01 Standby, 2'b10 Suspend, 2'b11 Hibernate. An enable value of 1 means the clock is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| wb_reached | input | 1 | Requesting instruction is at writeback |
| bus_idle | input | 1 | Internal system bus is idle |
| irq | input | 1 | Accepted interrupt request |
| wake_tmr | input | 1 | Wake/timer interrupt |
| pwr_pin | input | 1 | Power button, active high |
| cd_n | input | 1 | Carrier detect, active low |
| core_clk_en | output | 1 | Core pipeline clock run enable |
| periph_clk_en | output | 1 | Peripheral interface clock run enable |
| mstr_clk_en | output | 1 | Master output clock run enable |
| tmr_clk_en | output | 1 | Timer/interrupt clock run enable |
| mode | output | 2 | Current power mode |

## Verification
Entry is tried in three patterns, and each one separates a different point:
- The gating conditions are already true when the request arrives. This exposes a design that enters too early or needs an extra cycle.
- `wb_reached` stays low for several cycles while the bus is idle. This shows whether the design waits for both conditions.
- A second, conflicting request arrives while the first is pending. This shows whether the first target is kept.

Wake is tried with each source against each mode. `irq` wakes Standby but must leave Hibernate asleep. The power pin, the low carrier-detect and the timer each wake Hibernate on their own. Between these cases, a behavioural model in the bench compares the mode and all four enables on every cycle.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wb_reached,
  input  logic       bus_idle,
  input  logic       irq,
  input  logic       wake_tmr,
  input  logic       pwr_pin,
  input  logic       cd_n,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       mstr_clk_en,
  output logic       tmr_clk_en,
  output logic [1:0] mode
);

  localparam logic [1:0] M_FULL = 2'b00;
  localparam logic [1:0] M_STBY = 2'b01;
  localparam logic [1:0] M_SUSP = 2'b10;
  localparam logic [1:0] M_HIBR = 2'b11;

  logic [1:0] mode_q, tgt_q;
  logic       pend_q;
  logic       safe, soft_wake, hard_wake;

  assign safe      = wb_reached & bus_idle;
  assign soft_wake = irq | wake_tmr;
  assign hard_wake = pwr_pin | wake_tmr | ~cd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FULL;
      tgt_q  <= M_FULL;
      pend_q <= 1'b0;
    end else begin
      case (mode_q)
        M_FULL: begin
          if (pend_q) begin
            if (safe) begin
              mode_q <= tgt_q;
              pend_q <= 1'b0;
            end
          end else if (req_valid && req_mode != M_FULL) begin
            pend_q <= 1'b1;
            tgt_q  <= req_mode;
          end
        end
        M_STBY, M_SUSP: if (soft_wake) mode_q <= M_FULL;
        default:        if (hard_wake) mode_q <= M_FULL;
      endcase
    end
  end

  assign mode          = mode_q;
  assign core_clk_en   = (mode_q == M_FULL);
  assign periph_clk_en = ~mode_q[1];
  assign mstr_clk_en   = (mode_q != M_HIBR);
  assign tmr_clk_en    = (mode_q != M_HIBR);

  // R4
  lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_FULL) |=> (mode == $past(mode) || mode == M_FULL));

  // R3
  entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FULL && !(wb_reached && bus_idle)) |=> (mode == M_FULL));

  // R8
  soft_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_STBY || mode == M_SUSP) && (irq || wake_tmr)) |=>
      (mode == M_FULL && core_clk_en && periph_clk_en && mstr_clk_en && tmr_clk_en));

  // R9
  hibr_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIBR && !pwr_pin && !wake_tmr && cd_n) |=> (mode == M_HIBR));

  // R7
  hibr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIBR) |-> (!core_clk_en && !periph_clk_en && !mstr_clk_en && !tmr_clk_en));

  // R3
  pend_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q) |-> (mode == M_FULL && core_clk_en && periph_clk_en));

endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, wb_reached = 0, bus_idle = 0;
  logic irq = 0, wake_tmr = 0, pwr_pin = 0, cd_n = 1;
  logic [1:0] req_mode = 0;
  logic core_clk_en, periph_clk_en, mstr_clk_en, tmr_clk_en;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int m_mode = 0, m_tgt = 0;
  bit m_pend = 0;
  bit done = 0;

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wb_reached(wb_reached), .bus_idle(bus_idle), .irq(irq), .wake_tmr(wake_tmr),
    .pwr_pin(pwr_pin), .cd_n(cd_n), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .mstr_clk_en(mstr_clk_en),
    .tmr_clk_en(tmr_clk_en), .mode(mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] exp_en(int md);
    case (md)
      1:       return 4'b0111;
      2:       return 4'b0011;
      3:       return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic chk(string r, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {mode,enables} actual=%b expected=%b", r, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {mode, core_clk_en, periph_clk_en, mstr_clk_en, tmr_clk_en};
  endfunction

  function automatic logic [5:0] want(int md);
    return {md[1:0], exp_en(md)};
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_tgt = 0;
    end else if (m_mode == 0) begin
      if (m_pend) begin
        if (wb_reached && bus_idle) begin m_mode = m_tgt; m_pend = 0; end
      end else if (req_valid && req_mode != 0) begin
        m_pend = 1; m_tgt = req_mode;
      end
    end else if (m_mode == 3) begin
      if (pwr_pin || wake_tmr || !cd_n) m_mode = 0;
    end else if (irq || wake_tmr) m_mode = 0;
  end

  // per-cycle comparison; the tag names the mode requirement in force
  always @(negedge clk) if (rst_n && !done) begin
    case (m_mode)
      1: chk("R5", outs(), want(m_mode));
      2: chk("R6", outs(), want(m_mode));
      3: chk("R7", outs(), want(m_mode));
      default: chk("R10", outs(), want(m_mode));
    endcase
  end

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(logic [1:0] code);
    req_valid = 1; req_mode = code; tick(1); req_valid = 0; req_mode = 0;
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    chk("R1", outs(), want(0));

    // code 00 does nothing, even with safe conditions present
    wb_reached = 1; bus_idle = 1;
    request(2'b00); tick(2);
    chk("R2", outs(), want(0));

    // standby, entry held until writeback reached
    wb_reached = 0;
    request(2'b01); tick(3);
    chk("R3", outs(), want(0));
    request(2'b11); tick(1);          // R4: conflicting request while pending
    wb_reached = 1; tick(1);
    chk("R3", outs(), want(1));
    chk("R4", outs(), want(1));
    chk("R5", outs(), want(1));
    request(2'b11); tick(1);          // ignored in standby
    chk("R4", outs(), want(1));
    irq = 1; tick(1); irq = 0;
    chk("R8", outs(), want(0));

    // suspend, conditions already met: enters after two edges
    request(2'b10);
    chk("R2", outs(), want(0));
    tick(1);
    chk("R6", outs(), want(2));
    tick(2);
    wake_tmr = 1; tick(1); wake_tmr = 0;
    chk("R8", outs(), want(0));

    // hibernate and its three wake sources
    request(2'b11); tick(1);
    chk("R7", outs(), want(3));
    irq = 1; tick(3); irq = 0;
    chk("R9", outs(), want(3));
    pwr_pin = 1; tick(1); pwr_pin = 0;
    chk("R9", outs(), want(0));

    request(2'b11); tick(2);
    cd_n = 0; tick(1); cd_n = 1;
    chk("R9", outs(), want(0));

    request(2'b11); tick(2);
    chk("R7", outs(), want(3));
    wake_tmr = 1; tick(1); wake_tmr = 0;
    chk("R9", outs(), want(0));

    // bus busy blocks entry even with writeback reached
    bus_idle = 0;
    request(2'b10); tick(4);
    chk("R3", outs(), want(0));
    bus_idle = 1; tick(1);
    chk("R6", outs(), want(2));
    irq = 1; tick(1); irq = 0;
    chk("R8", outs(), want(0));

    tick(2);
    finish_up();
  end
endmodule